// File: doc/BRIEF.md
# SDA Hold Delay and Line Filter

This block sits between the serial shift logic of a two-wire bus controller and the bus pins. On the output side it retimes the SDA pull-down request so that, after each falling edge of the controller's SCL, the data line keeps its old value for a programmable number of system clocks. This gives the bus a guaranteed data hold time that does not depend on how quickly the shift logic reacts. Outside that hold window the request passes through one output register.

On the input side both sampled lines (SDA and SCL) are brought into the clock domain through a two-stage synchronizer. An optional majority-free glitch filter can be switched in; it only accepts a new level once it has been seen unchanged for three system clocks in a row.

Configuration is a 3-bit control word loaded with a write strobe. The two low bits pick the hold step (0, 5, 10 or 15 clocks), and the top bit enables the input filter. After reset the word is zero: no hold delay and no filter.

Top module: `sda_hold_conditioner`

## Requirements
- R1: After reset `sda_oe_o` is 0, `sda_filt_o` and `scl_filt_o` are 1, and the control word is zero (no hold delay, filter off).
- R2: The control word is loaded from `cfg_data_i` only on a clock edge where `cfg_wr_i` is 1; bits [1:0] are the delay code and bit [2] is the filter enable. With `cfg_wr_i` at 0 the value on `cfg_data_i` has no effect.
- R3: Delay code 00, 01, 10, 11 gives a hold of 0, 5, 10, 15 clocks: if edge k is the first edge at which `scl_i` is sampled low after being high, `sda_oe_o` takes the value of `sda_oe_req_i` at edge k+D.
- R4: During a hold window with SCL low, `sda_oe_o` does not change, and request changes inside the window are absorbed; the value applied at the end is the request present at that edge.
- R5: If `scl_i` is sampled high while a hold window is open, the window ends and the current request is applied at that same edge.
- R6: Outside a hold window, `sda_oe_o` equals the request sampled at the previous edge.
- R7: With the filter off, a change on `sda_pin_i` or `scl_pin_i` reaches the filtered output after two clock edges.
- R8: With the filter on, a new input level is accepted only after three consecutive synchronized samples at that level, so a pin change reaches the output after five edges and a pulse of two clocks or less is suppressed.
- R9: The SCL input path uses the same synchronizer and filter as the SDA path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Load strobe for the control word |
| cfg_data_i | input | 3 | Control word: [1:0] delay code, [2] filter enable |
| sda_oe_req_i | input | 1 | SDA pull-down request from the shift logic (1 = drive low) |
| scl_i | input | 1 | SCL level as driven by the controller |
| sda_pin_i | input | 1 | Raw SDA pin level |
| scl_pin_i | input | 1 | Raw SCL pin level |
| sda_oe_o | output | 1 | Retimed SDA pull-down enable |
| sda_filt_o | output | 1 | Synchronized, optionally filtered SDA level |
| scl_filt_o | output | 1 | Synchronized, optionally filtered SCL level |

## Verification
A wrong hold counter shows as `sda_oe_o` moving one or more edges too early or too late after an SCL fall, so each delay code is checked on the exact edge before and the edge of the expected change. A stuck window flag shows either as a request that is never applied or as one that leaks through mid-window; the early-rise case catches a window that ignores SCL within one edge. A miscounted filter run length shows within five edges of a pin change, either as a two-clock glitch passing or as a true change arriving on the wrong edge.

// File: rtl/sda_cond_pkg.sv
`timescale 1ns/1ps
package sda_cond_pkg;
  // Width of the hold delay code in the control word
  localparam int unsigned CODE_W = 2;

  typedef struct packed {
    logic              filt_en;
    logic [CODE_W-1:0] step;
  } line_cfg_t;
endpackage

// File: rtl/sda_line_filter.sv
`timescale 1ns/1ps
// Synchronizer plus optional run-length glitch filter for one input line.
module sda_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pin_i,
  output logic line_o
);
  localparam int unsigned RUN_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic                   filt_q, filt_d;
  logic [RUN_W-1:0]       run_q, run_d;

  assign synced = sync_q[SYNC_STAGES-1];

  always_comb begin
    filt_d = filt_q;
    run_d  = run_q;
    if (!en_i) begin
      filt_d = synced;
      run_d  = '0;
    end else if (synced == filt_q) begin
      run_d = '0;
    end else if (run_q == RUN_LAST) begin
      filt_d = synced;
      run_d  = '0;
    end else begin
      run_d = run_q + RUN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      filt_q <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      filt_q <= filt_d;
      run_q  <= run_d;
    end
  end

  assign line_o = en_i ? filt_q : synced;
endmodule

// File: rtl/sda_hold_delay.sv
`timescale 1ns/1ps
// Holds the SDA output after an SCL fall for step*STEP_CLKS clocks.
module sda_hold_delay #(
  parameter int unsigned STEP_CLKS = 5,
  parameter int unsigned CODE_W    = 2,
  parameter int unsigned CNT_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] step_i,
  input  logic              req_i,
  input  logic              scl_i,
  output logic              oe_o,
  output logic              hold_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  lim_o
);
  logic             scl_q;
  logic             scl_fall;
  logic [CNT_W-1:0] lim_c;
  logic             hold_q, hold_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             oe_q, oe_d;

  assign lim_c    = CNT_W'(step_i) * CNT_W'(STEP_CLKS);
  assign scl_fall = scl_q & ~scl_i;

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    oe_d   = oe_q;
    if (hold_q) begin
      // window closes on count reached or an early SCL rise
      if (scl_i || (cnt_q >= lim_c)) begin
        hold_d = 1'b0;
        cnt_d  = '0;
        oe_d   = req_i;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (scl_fall && (lim_c != '0)) begin
      hold_d = 1'b1;
      cnt_d  = CNT_W'(1);
    end else begin
      oe_d = req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      hold_q <= 1'b0;
      cnt_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      scl_q  <= scl_i;
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
      oe_q   <= oe_d;
    end
  end

  assign oe_o   = oe_q;
  assign hold_o = hold_q;
  assign cnt_o  = cnt_q;
  assign lim_o  = lim_c;
endmodule

// File: rtl/sda_hold_conditioner.sv
`timescale 1ns/1ps
module sda_hold_conditioner
  import sda_cond_pkg::*;
#(
  parameter int unsigned STEP_CLKS   = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_wr_i,
  input  logic [CODE_W:0] cfg_data_i,
  input  logic            sda_oe_req_i,
  input  logic            scl_i,
  input  logic            sda_pin_i,
  input  logic            scl_pin_i,
  output logic            sda_oe_o,
  output logic            sda_filt_o,
  output logic            scl_filt_o
);
  localparam int unsigned MAX_DLY = ((2 ** CODE_W) - 1) * STEP_CLKS;
  localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);
  localparam int unsigned LINES   = 2;

  line_cfg_t        cfg_q, cfg_d;
  logic             hold_act;
  logic [CNT_W-1:0] hold_cnt;
  logic [CNT_W-1:0] hold_lim;
  logic [LINES-1:0] pin_v;
  logic [LINES-1:0] line_v;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr_i) cfg_d = line_cfg_t'(cfg_data_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  sda_hold_delay #(
    .STEP_CLKS (STEP_CLKS),
    .CODE_W    (CODE_W),
    .CNT_W     (CNT_W)
  ) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (cfg_q.step),
    .req_i  (sda_oe_req_i),
    .scl_i  (scl_i),
    .oe_o   (sda_oe_o),
    .hold_o (hold_act),
    .cnt_o  (hold_cnt),
    .lim_o  (hold_lim)
  );

  assign pin_v = {scl_pin_i, sda_pin_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    sda_line_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN)
    ) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (cfg_q.filt_en),
      .pin_i  (pin_v[g]),
      .line_o (line_v[g])
    );
  end

  assign sda_filt_o = line_v[0];
  assign scl_filt_o = line_v[1];
endmodule

// File: rtl/sda_hold_conditioner_chk.sv
`timescale 1ns/1ps
module sda_hold_conditioner_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             scl_i,
  input logic             oe_i,
  input logic             hold_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] lim_i
);
  logic scl_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_seen_q <= 1'b1;
    else         scl_seen_q <= scl_i;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !scl_i && (cnt_i < lim_i)) |=> $stable(oe_i));  // R4

  AST_EARLY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && scl_i) |=> (!hold_i && (oe_i == $past(req_i))));  // R5

  AST_HOLD_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && (cnt_i >= lim_i)) |=> !hold_i);  // R3

  AST_FOLLOW_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !(scl_seen_q && !scl_i && (lim_i != '0))) |=> (oe_i == $past(req_i)));  // R6
endmodule

bind sda_hold_conditioner sda_hold_conditioner_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (sda_oe_req_i),
  .scl_i  (scl_i),
  .oe_i   (sda_oe_o),
  .hold_i (hold_act),
  .cnt_i  (hold_cnt),
  .lim_i  (hold_lim)
);

// File: tb/sda_hold_conditioner_bench.sv
`timescale 1ns/1ps
module sda_hold_conditioner_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cfg_wr_i;
  logic [2:0] cfg_data_i;
  logic       sda_oe_req_i;
  logic       scl_i;
  logic       sda_pin_i;
  logic       scl_pin_i;
  logic       sda_oe_o;
  logic       sda_filt_o;
  logic       scl_filt_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk_i = ~clk_i;

  sda_hold_conditioner u_sda_hold_conditioner (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_data_i   (cfg_data_i),
    .sda_oe_req_i (sda_oe_req_i),
    .scl_i        (scl_i),
    .sda_pin_i    (sda_pin_i),
    .scl_pin_i    (scl_pin_i),
    .sda_oe_o     (sda_oe_o),
    .sda_filt_o   (sda_filt_o),
    .scl_filt_o   (scl_filt_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] val);
    cfg_wr_i   = 1'b1;
    cfg_data_i = val;
    step(1);
    cfg_wr_i   = 1'b0;
    cfg_data_i = 3'b000;
  endtask

  // bring SCL high and request low, output settled at 0
  task automatic settle_low();
    scl_i        = 1'b1;
    sda_oe_req_i = 1'b0;
    step(3);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe_o after reset", sda_oe_o, 1'b0);
    chk("R1 sda_filt_o after reset", sda_filt_o, 1'b1);
    chk("R1 scl_filt_o after reset", scl_filt_o, 1'b1);
    // zero control word: no hold delay
    settle_low();
    scl_i = 1'b0; sda_oe_req_i = 1'b1;
    step(1);
    chk("R1 default zero delay", sda_oe_o, 1'b1);
  endtask

  task automatic t_cfg_ignored();
    settle_low();
    cfg_wr_i = 1'b0; cfg_data_i = 3'b011;
    step(1);
    cfg_data_i = 3'b000;
    scl_i = 1'b0; sda_oe_req_i = 1'b1;
    step(1);
    chk("R2 data without strobe ignored", sda_oe_o, 1'b1);
  endtask

  task automatic t_delay(input logic [1:0] code);
    int d;
    d = int'(code) * 5;
    write_cfg({1'b0, code});
    settle_low();
    scl_i = 1'b0; sda_oe_req_i = 1'b1;
    if (d > 0) begin
      step(d);
      chk($sformatf("R3 code %0d held at edge %0d", code, d), sda_oe_o, 1'b0);
    end
    step(1);
    chk($sformatf("R3 code %0d applied at edge %0d", code, d + 1), sda_oe_o, 1'b1);
  endtask

  task automatic t_absorb();
    write_cfg(3'b010);
    settle_low();
    scl_i = 1'b0; sda_oe_req_i = 1'b1;
    step(4);
    chk("R4 held early in window", sda_oe_o, 1'b0);
    sda_oe_req_i = 1'b0;
    step(3);
    chk("R4 held mid window", sda_oe_o, 1'b0);
    sda_oe_req_i = 1'b1;
    step(3);
    chk("R4 held at last window edge", sda_oe_o, 1'b0);
    step(1);
    chk("R4 final request applied", sda_oe_o, 1'b1);
  endtask

  task automatic t_early_rise();
    write_cfg(3'b011);
    settle_low();
    scl_i = 1'b0; sda_oe_req_i = 1'b1;
    step(4);
    chk("R5 held before rise", sda_oe_o, 1'b0);
    scl_i = 1'b1;
    step(1);
    chk("R5 applied on early SCL rise", sda_oe_o, 1'b1);
  endtask

  task automatic t_follow();
    write_cfg(3'b011);
    settle_low();
    sda_oe_req_i = 1'b1;
    step(1);
    chk("R6 follows with SCL high", sda_oe_o, 1'b1);
    sda_oe_req_i = 1'b0;
    step(1);
    chk("R6 follows back with SCL high", sda_oe_o, 1'b0);
    scl_i = 1'b0;
    step(20);
    sda_oe_req_i = 1'b1;
    step(1);
    chk("R6 follows with SCL low after window", sda_oe_o, 1'b1);
  endtask

  task automatic t_filter_off();
    write_cfg(3'b000);
    sda_pin_i = 1'b1; scl_pin_i = 1'b1;
    step(6);
    sda_pin_i = 1'b0;
    step(1);
    chk("R7 sda not yet through sync", sda_filt_o, 1'b1);
    step(1);
    chk("R7 sda through sync after 2 edges", sda_filt_o, 1'b0);
    scl_pin_i = 1'b0;
    step(2);
    chk("R7 scl through sync after 2 edges", scl_filt_o, 1'b0);
  endtask

  task automatic t_filter_on();
    write_cfg(3'b100);
    sda_pin_i = 1'b1; scl_pin_i = 1'b1;
    step(8);
    sda_pin_i = 1'b0;
    step(4);
    chk("R8 sda held until third sample", sda_filt_o, 1'b1);
    step(1);
    chk("R8 sda accepted at edge 5", sda_filt_o, 1'b0);
    sda_pin_i = 1'b1;
    step(8);
    // two-clock glitch must not pass
    sda_pin_i = 1'b0;
    step(2);
    sda_pin_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk($sformatf("R8 glitch suppressed step %0d", i), sda_filt_o, 1'b1);
    end
    // three-clock pulse passes
    sda_pin_i = 1'b0;
    step(3);
    sda_pin_i = 1'b1;
    step(2);
    chk("R8 three-clock pulse accepted", sda_filt_o, 1'b0);
    step(6);
  endtask

  task automatic t_scl_filter();
    write_cfg(3'b100);
    scl_pin_i = 1'b1;
    step(8);
    scl_pin_i = 1'b0;
    step(4);
    chk("R9 scl held until third sample", scl_filt_o, 1'b1);
    step(1);
    chk("R9 scl accepted at edge 5", scl_filt_o, 1'b0);
    scl_pin_i = 1'b1;
    step(1);
    scl_pin_i = 1'b0;
    step(6);
    chk("R9 scl one-clock glitch suppressed", scl_filt_o, 1'b0);
  endtask

  initial begin
    rst_ni = 1'b0; cfg_wr_i = 1'b0; cfg_data_i = 3'b000;
    sda_oe_req_i = 1'b0; scl_i = 1'b1; sda_pin_i = 1'b1; scl_pin_i = 1'b1;
    step(3);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_cfg_ignored();
    t_delay(2'b00);
    t_delay(2'b01);
    t_delay(2'b10);
    t_delay(2'b11);
    t_absorb();
    t_early_rise();
    t_follow();
    t_filter_off();
    t_filter_on();
    t_scl_filter();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule